// File: doc/BRIEF.md
# Commit Address Control-Flow Monitor

This block watches the commit stage of a pipelined processor and catches control-flow errors. Every instruction that commits brings three things with it: its own address, the address it resolved as its successor, and a bubble flag. The successor is the next sequential address unless a branch rewrote it earlier in the pipeline. The monitor holds the successor of the last good commit in an expected-address register. It compares the address of each new commit against that register.

A commit that matches is accepted, and its successor becomes the new expected address. A commit that differs raises a one-cycle error and a one-cycle flush request. It also presents the previously expected address as the fetch redirect target. After a flush, whether the monitor raised it or the pipeline did, the register is invalid. The next real commit is then taken unchecked so that the expected address can be set up again. The register contents also serve as the lookup address for an instruction-signature table, qualified by a valid bit.

Top module: `cf_commit_monitor`

## Requirements
- R1: After reset, `flush_req`, `cf_error` and `sig_lookup_valid` are 0.
- R2: With the expected register invalid, a commit (`cm_valid`=1, `cm_bubble`=0, `pipe_flush`=0) is accepted without comparison. From the next cycle, `sig_lookup_valid`=1 and `sig_lookup_addr` equals that commit's `cm_next_pc`.
- R3: With the register valid, a commit whose `cm_pc` equals the register raises no flush. The register then loads that commit's `cm_next_pc`.
- R4: With the register valid, a commit whose `cm_pc` differs from the register causes the following effect in the cycle after the commit edge. `flush_req` and `cf_error` are both 1, and `redirect_pc` equals the register value held before that commit.
- R5: A mismatching commit does not load its `cm_next_pc`. Instead the register becomes invalid (`sig_lookup_valid`=0 the next cycle).
- R6: The first commit after a flush raised by the monitor is accepted without comparison, as in R2.
- R7: A commit with `cm_bubble`=1 is ignored. It raises no flush and leaves `sig_lookup_addr` and `sig_lookup_valid` unchanged.
- R8: `pipe_flush`=1 invalidates the register and takes priority over a commit in the same cycle. That commit is neither checked nor loaded, and no flush is raised.
- R9: `sig_lookup_addr` always shows the expected register, and `sig_lookup_valid` shows whether it is valid.
- R10: `flush_req` and `cf_error` are asserted for exactly one cycle per mismatch and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cm_valid | input | 1 | An instruction commits this cycle |
| cm_bubble | input | 1 | The committing slot is annulled |
| cm_pc | input | ADDR_W | Address of the committing instruction |
| cm_next_pc | input | ADDR_W | Resolved successor address of that instruction |
| pipe_flush | input | 1 | Pipeline flush from elsewhere; invalidates expectation |
| flush_req | output | 1 | One-cycle flush request on a mismatch |
| cf_error | output | 1 | One-cycle control-flow error indication |
| redirect_pc | output | ADDR_W | Fetch restart address, valid with `flush_req` |
| sig_lookup_addr | output | ADDR_W | Expected address, for the signature table lookup |
| sig_lookup_valid | output | 1 | The expected address is valid |

## Verification
A corrupted expected register is visible at once on `sig_lookup_addr` and `sig_lookup_valid`, in the cycle after the load that wrote it. It also shows one cycle after the next real commit: a good instruction stream then raises a spurious `flush_req` with a wrong `redirect_pc`. A lost invalidation shows the same way. After a flush, a commit that should be taken unchecked instead raises a flush. A wrong load condition, such as a bubble or a mismatching commit loading its successor, shows on `sig_lookup_addr` one cycle after that commit.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

  // Outcome of one cycle at the commit port
  typedef enum logic [1:0] {
    CMP_IDLE  = 2'd0,  // nothing to check (no commit, bubble, or external flush)
    CMP_FIRST = 2'd1,  // commit accepted unchecked, expectation invalid
    CMP_MATCH = 2'd2,  // commit address equals expectation
    CMP_MISS  = 2'd3   // commit address differs from expectation
  } cmp_kind_e;

  // Classify a commit slot. External flush beats everything.
  function automatic cmp_kind_e classify(input logic valid,
                                         input logic bubble,
                                         input logic ext_flush,
                                         input logic exp_valid,
                                         input logic addr_eq);
    cmp_kind_e k;
    if (!valid || bubble || ext_flush) k = CMP_IDLE;
    else if (!exp_valid)               k = CMP_FIRST;
    else if (addr_eq)                  k = CMP_MATCH;
    else                               k = CMP_MISS;
    return k;
  endfunction

  function automatic logic kind_loads(input cmp_kind_e k);
    return (k == CMP_FIRST) || (k == CMP_MATCH);
  endfunction

endpackage

// File: rtl/cfm_compare.sv
module cfm_compare
  import cfm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              commit_valid,
  input  logic              commit_bubble,
  input  logic              ext_flush,
  input  logic              exp_valid,
  input  logic [ADDR_W-1:0] exp_addr,
  input  logic [ADDR_W-1:0] commit_pc,
  output cmp_kind_e         kind,
  output logic              accept,
  output logic              mismatch
);

  logic addr_eq;

  always_comb begin
    addr_eq  = (commit_pc == exp_addr);
    kind     = classify(commit_valid, commit_bubble, ext_flush, exp_valid, addr_eq);
    accept   = kind_loads(kind);
    mismatch = (kind == CMP_MISS);
  end

endmodule

// File: rtl/cfm_expect_reg.sv
module cfm_expect_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              invalidate,
  output logic [ADDR_W-1:0] exp_addr,
  output logic              exp_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_addr  <= '0;
      exp_valid <= 1'b0;
    end else if (invalidate) begin
      exp_valid <= 1'b0;
    end else if (load) begin
      exp_addr  <= load_addr;
      exp_valid <= 1'b1;
    end
  end

endmodule

// File: rtl/cfm_redirect.sv
module cfm_redirect #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trigger,
  input  logic [ADDR_W-1:0] target,
  output logic              flush_req,
  output logic              err_pulse,
  output logic [ADDR_W-1:0] redirect_pc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_req   <= 1'b0;
      err_pulse   <= 1'b0;
      redirect_pc <= '0;
    end else begin
      flush_req <= trigger;
      err_pulse <= trigger;
      if (trigger) redirect_pc <= target;
    end
  end

endmodule

// File: rtl/cf_commit_monitor.sv
module cf_commit_monitor
  import cfm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cm_valid,
  input  logic              cm_bubble,
  input  logic [ADDR_W-1:0] cm_pc,
  input  logic [ADDR_W-1:0] cm_next_pc,
  input  logic              pipe_flush,
  output logic              flush_req,
  output logic              cf_error,
  output logic [ADDR_W-1:0] redirect_pc,
  output logic [ADDR_W-1:0] sig_lookup_addr,
  output logic              sig_lookup_valid
);

  // Named internal events, observed by the bound checker
  cmp_kind_e         chk_kind;
  logic              chk_accept;
  logic              chk_mismatch;
  logic              chk_invalidate;
  logic [ADDR_W-1:0] exp_addr;
  logic              exp_valid;

  cfm_compare #(.ADDR_W(ADDR_W)) u_cmp (
    .commit_valid (cm_valid),
    .commit_bubble(cm_bubble),
    .ext_flush    (pipe_flush),
    .exp_valid    (exp_valid),
    .exp_addr     (exp_addr),
    .commit_pc    (cm_pc),
    .kind         (chk_kind),
    .accept       (chk_accept),
    .mismatch     (chk_mismatch)
  );

  assign chk_invalidate = pipe_flush | chk_mismatch;

  cfm_expect_reg #(.ADDR_W(ADDR_W)) u_exp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (chk_accept),
    .load_addr (cm_next_pc),
    .invalidate(chk_invalidate),
    .exp_addr  (exp_addr),
    .exp_valid (exp_valid)
  );

  cfm_redirect #(.ADDR_W(ADDR_W)) u_rdr (
    .clk        (clk),
    .rst_n      (rst_n),
    .trigger    (chk_mismatch),
    .target     (exp_addr),
    .flush_req  (flush_req),
    .err_pulse  (cf_error),
    .redirect_pc(redirect_pc)
  );

  assign sig_lookup_addr  = exp_addr;
  assign sig_lookup_valid = exp_valid;

endmodule

// File: rtl/cfm_checker.sv
module cfm_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cm_valid,
  input logic              cm_bubble,
  input logic [ADDR_W-1:0] cm_next_pc,
  input logic              pipe_flush,
  input logic              flush_req,
  input logic              cf_error,
  input logic [ADDR_W-1:0] redirect_pc,
  input logic [ADDR_W-1:0] sig_lookup_addr,
  input logic              sig_lookup_valid,
  input logic              accept,
  input logic              mismatch
);

  assert_accept_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (sig_lookup_valid && sig_lookup_addr == $past(cm_next_pc)));

  assert_miss_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> (flush_req && cf_error && redirect_pc == $past(sig_lookup_addr)));

  assert_miss_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> !sig_lookup_valid);

  assert_bubble_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && cm_bubble && !pipe_flush) |=>
      ($stable(sig_lookup_addr) && $stable(sig_lookup_valid) && !flush_req));

  assert_ext_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_flush |=> (!sig_lookup_valid && !flush_req));

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !flush_req);

  assert_err_with_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cf_error) |-> flush_req);

endmodule

bind cf_commit_monitor cfm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cm_valid        (cm_valid),
  .cm_bubble       (cm_bubble),
  .cm_next_pc      (cm_next_pc),
  .pipe_flush      (pipe_flush),
  .flush_req       (flush_req),
  .cf_error        (cf_error),
  .redirect_pc     (redirect_pc),
  .sig_lookup_addr (sig_lookup_addr),
  .sig_lookup_valid(sig_lookup_valid),
  .accept          (chk_accept),
  .mismatch        (chk_mismatch)
);

// File: tb/sim_cf_commit_monitor.sv
`timescale 1ns/1ps
module sim_cf_commit_monitor;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cm_valid, cm_bubble, pipe_flush;
  logic [AW-1:0] cm_pc, cm_next_pc;
  logic          flush_req, cf_error, sig_lookup_valid;
  logic [AW-1:0] redirect_pc, sig_lookup_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  cf_commit_monitor #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cm_valid(cm_valid), .cm_bubble(cm_bubble),
    .cm_pc(cm_pc), .cm_next_pc(cm_next_pc),
    .pipe_flush(pipe_flush),
    .flush_req(flush_req), .cf_error(cf_error),
    .redirect_pc(redirect_pc),
    .sig_lookup_addr(sig_lookup_addr), .sig_lookup_valid(sig_lookup_valid)
  );

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one slot at a negedge; return at the next negedge with results visible
  task automatic slot(input logic v, input logic [AW-1:0] pc, input logic [AW-1:0] nx,
                      input logic bub, input logic fl);
    cm_valid = v; cm_pc = pc; cm_next_pc = nx; cm_bubble = bub; pipe_flush = fl;
    @(posedge clk);
    @(negedge clk);
    cm_valid = 1'b0; cm_bubble = 1'b0; pipe_flush = 1'b0;
  endtask

  task automatic expect_quiet(input string tag, input logic [AW-1:0] addr);
    check({tag, " flush_req"}, {31'd0, flush_req}, 32'd0);
    check({tag, " cf_error"}, {31'd0, cf_error}, 32'd0);
    check({tag, " sig_valid"}, {31'd0, sig_lookup_valid}, 32'd1);
    check({tag, " sig_addr"}, sig_lookup_addr, addr);
  endtask

  task automatic t_reset;
    check("R1 flush_req", {31'd0, flush_req}, 32'd0);
    check("R1 cf_error", {31'd0, cf_error}, 32'd0);
    check("R1 sig_valid", {31'd0, sig_lookup_valid}, 32'd0);
  endtask

  task automatic t_first;
    slot(1'b1, 32'h0000_0100, 32'h0000_0104, 1'b0, 1'b0);
    expect_quiet("R2 R9 first", 32'h0000_0104);
  endtask

  task automatic t_chain;
    slot(1'b1, 32'h0000_0104, 32'h0000_0108, 1'b0, 1'b0);
    expect_quiet("R3 seq", 32'h0000_0108);
    slot(1'b1, 32'h0000_0108, 32'h0000_0200, 1'b0, 1'b0);
    expect_quiet("R3 branch", 32'h0000_0200);
    slot(1'b1, 32'h0000_0200, 32'h0000_0204, 1'b0, 1'b0);
    expect_quiet("R3 target", 32'h0000_0204);
    slot(1'b0, 32'h0000_0aaa, 32'h0000_0bbb, 1'b0, 1'b0);
    expect_quiet("R9 idle", 32'h0000_0204);
  endtask

  task automatic t_bubble;
    slot(1'b1, 32'hdead_0000, 32'hbeef_0000, 1'b1, 1'b0);
    expect_quiet("R7 bubble", 32'h0000_0204);
  endtask

  task automatic t_miss;
    slot(1'b1, 32'h0000_0300, 32'h0000_0304, 1'b0, 1'b0);
    check("R4 flush_req", {31'd0, flush_req}, 32'd1);
    check("R4 cf_error", {31'd0, cf_error}, 32'd1);
    check("R4 redirect_pc", redirect_pc, 32'h0000_0204);
    check("R5 sig_valid", {31'd0, sig_lookup_valid}, 32'd0);
    // immediately a commit that would mismatch the stale value: accepted unchecked
    slot(1'b1, 32'h0000_0500, 32'h0000_0504, 1'b0, 1'b0);
    check("R10 flush_req", {31'd0, flush_req}, 32'd0);
    check("R10 cf_error", {31'd0, cf_error}, 32'd0);
    check("R6 R5 sig_addr", sig_lookup_addr, 32'h0000_0504);
    check("R6 sig_valid", {31'd0, sig_lookup_valid}, 32'd1);
  endtask

  task automatic t_ext_flush;
    slot(1'b1, 32'h0000_0504, 32'h0000_0508, 1'b0, 1'b1);
    check("R8 sig_valid", {31'd0, sig_lookup_valid}, 32'd0);
    check("R8 flush_req", {31'd0, flush_req}, 32'd0);
    check("R8 sig_addr kept", sig_lookup_addr, 32'h0000_0504);
    slot(1'b1, 32'h0000_0999, 32'h0000_099d, 1'b0, 1'b0);
    expect_quiet("R8 R2 after flush", 32'h0000_099d);
    slot(1'b1, 32'h0000_0998, 32'h0000_0a00, 1'b0, 1'b0);
    check("R4 second miss", {31'd0, flush_req}, 32'd1);
    check("R4 second redirect", redirect_pc, 32'h0000_099d);
    slot(1'b0, 32'h0, 32'h0, 1'b0, 1'b0);
    check("R10 drop", {31'd0, flush_req}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; cm_valid = 1'b0; cm_bubble = 1'b0; pipe_flush = 1'b0;
    cm_pc = '0; cm_next_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first();
    t_chain();
    t_bubble();
    t_miss();
    t_ext_flush();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule